// File: doc/BRIEF.md
# Fixed-Latency Guarded Multiply-and-Capture Sequencer

This block runs one fixed-length schedule each time it is started. A start pulse on `go` launches a relative cycle counter that steps through exactly `LATENCY` cycles and then returns to idle. Half-open windows over that counter become guard signals. Each guard enables one group of output assignments during its own cycles and forces those outputs to zero at every other time.

The default schedule drives an external pipelined multiplier that has a fixed latency of three cycles and no completion port. The constant operands 6 and 7, together with the multiplier's `go`, are driven during relative cycles 0 to 2. In relative cycle 3 the multiplier's result is handed to a register write port, with its write enable asserted for that one cycle. The block has no done output. A client relies on the fixed latency instead: the product is in the target register after the edge that ends relative cycle 3.

Top module: `fixed_latency_group`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the unit is idle and every output (`mul_a`, `mul_b`, `mul_go`, `reg_wdata`, `reg_we`) is 0.
- R2: A `go` sampled high at a rising edge while the unit is idle makes the next cycle relative cycle 0. The unit then stays busy for exactly `LATENCY` (default 4) consecutive cycles, numbered 0 to `LATENCY-1`.
- R3: `mul_go` is 1 exactly in relative cycles in the window [0:`MUL_LAT`), which is cycles 0, 1 and 2 by default. In those cycles `mul_a` = 6 and `mul_b` = 7, and at all other times all three outputs are 0.
- R4: `reg_we` is 1 only in the single-cycle window at relative cycle `LATENCY-1` (cycle 3 by default), so it is never high on two consecutive cycles within one run. At all other times both `reg_we` and `reg_wdata` are 0.
- R5: A `go` sampled while the unit is busy has no effect, and this includes a `go` in the last cycle. The schedule already running completes unchanged, and no new run follows it.
- R6: After the last relative cycle the unit is idle, and every guard stays low until the next accepted `go`. A `go` in the first idle cycle starts a new run immediately, with no gap cycle.
- R7: In relative cycle `LATENCY-1`, `reg_wdata` equals `mul_p`. With a three-cycle multiplier and operands 6 and 7, that value is 42, and the target register holds 42 once the run ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start pulse, accepted only while idle |
| mul_a | output | WIDTH | First multiplier operand, guarded |
| mul_b | output | WIDTH | Second multiplier operand, guarded |
| mul_go | output | 1 | Multiplier start, guarded |
| mul_p | input | 2*WIDTH | Multiplier result |
| reg_wdata | output | 2*WIDTH | Write data for the target register, guarded |
| reg_we | output | 1 | Write enable for the target register, guarded |

## Verification
The bench builds the block with its default values: `LATENCY` 4, `MUL_LAT` 3, `WIDTH` 8 and operands 6 and 7. With these values the capture cycle comes straight after the operand window. If either window boundary moves by one cycle, the result is a missing write, a write of 0, or a write on the wrong cycle. Any of these shows up as a mismatch against the behavioural per-cycle model and the expected value of 42. Start pulses are placed in every relative cycle of a run, including the last one, and `go` is also held high for many cycles. This exercises both the busy-time rejection and restart in the first idle cycle.

// File: rtl/fixed_group_pkg.sv
// Package: fixed_group_pkg
// Shared constants and helpers for the fixed-latency group sequencer.
// Assumes relative cycle numbers fit in a signed int.
package fixed_group_pkg;

    // Index of each guard in the guard vector
    localparam int GUARD_OPS  = 0;  // operand and multiplier-start window
    localparam int GUARD_CAP  = 1;  // result capture window
    localparam int NUM_GUARDS = 2;

    // True when rel lies in the half-open window [lo:hi)
    function automatic logic in_window(input int rel, input int lo, input int hi);
        return (rel >= lo) && (rel < hi);
    endfunction

endpackage

// File: rtl/group_timer.sv
// Module: group_timer
// Relative cycle counter for one fixed-length run. An idle unit accepts go,
// counts 0..LATENCY-1 while busy, then returns to idle. It ignores go while busy.
// Assumes LATENCY >= 1.
module group_timer #(
    parameter int LATENCY = 4,
    localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          busy,
    output logic [CW-1:0] rel
);

    localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

    // Advance the run state and the relative cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            rel  <= '0;
        end else if (!busy) begin
            busy <= go;
            rel  <= '0;
        end else if (rel == LAST) begin
            busy <= 1'b0;
            rel  <= '0;
        end else begin
            rel <= rel + 1'b1;
        end
    end

endmodule

// File: rtl/window_guard.sv
// Module: window_guard
// Decodes one half-open window [LO:HI) of the relative counter into a guard.
// The guard is low whenever the unit is idle. Assumes 0 <= LO < HI.
module window_guard #(
    parameter int LO = 0,
    parameter int HI = 1,
    parameter int CW = 2
) (
    input  logic          busy,
    input  logic [CW-1:0] rel,
    output logic          hit
);

    // Compare the counter against the window bounds
    always_comb begin
        hit = busy && fixed_group_pkg::in_window(int'(rel), LO, HI);
    end

endmodule

// File: rtl/guarded_assign.sv
// Module: guarded_assign
// Passes val to dout while en is high and drives zero otherwise.
// Assumes val is stable for the whole cycle in which en is high.
module guarded_assign #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] val,
    output logic [W-1:0] dout
);

    // Select the guarded value or zero
    always_comb begin
        dout = en ? val : '0;
    end

endmodule

// File: rtl/fixed_latency_group.sv
// Module: fixed_latency_group
// Fixed-latency group: after an accepted go it runs exactly LATENCY cycles.
// The operands and the multiplier start are driven in window [0:MUL_LAT), and
// the multiplier result goes to the register write port at cycle LATENCY-1.
// Assumes an external multiplier whose result is valid MUL_LAT cycles after
// its inputs, and LATENCY >= MUL_LAT + 1.
module fixed_latency_group #(
    parameter int WIDTH   = 8,
    parameter int LATENCY = 4,
    parameter int MUL_LAT = 3,
    parameter int OP_A    = 6,
    parameter int OP_B    = 7,
    localparam int PW = 2 * WIDTH,
    localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic [WIDTH-1:0] mul_a,
    output logic [WIDTH-1:0] mul_b,
    output logic          mul_go,
    input  logic [PW-1:0] mul_p,
    output logic [PW-1:0] reg_wdata,
    output logic          reg_we
);

    import fixed_group_pkg::*;

    logic          busy;
    logic [CW-1:0] rel;
    logic [NUM_GUARDS-1:0] guard;

    group_timer #(.LATENCY(LATENCY)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (go),
        .busy (busy),
        .rel  (rel)
    );

    // One decoder per guard window
    for (genvar g = 0; g < NUM_GUARDS; g++) begin : g_guard
        localparam int LO = (g == GUARD_OPS) ? 0 : LATENCY - 1;
        localparam int HI = (g == GUARD_OPS) ? MUL_LAT : LATENCY;
        window_guard #(.LO(LO), .HI(HI), .CW(CW)) u_win (
            .busy(busy),
            .rel (rel),
            .hit (guard[g])
        );
    end

    guarded_assign #(.W(WIDTH)) u_drv_a (
        .en  (guard[GUARD_OPS]),
        .val (WIDTH'(OP_A)),
        .dout(mul_a)
    );

    guarded_assign #(.W(WIDTH)) u_drv_b (
        .en  (guard[GUARD_OPS]),
        .val (WIDTH'(OP_B)),
        .dout(mul_b)
    );

    guarded_assign #(.W(1)) u_drv_go (
        .en  (guard[GUARD_OPS]),
        .val (1'b1),
        .dout(mul_go)
    );

    guarded_assign #(.W(PW)) u_drv_wd (
        .en  (guard[GUARD_CAP]),
        .val (mul_p),
        .dout(reg_wdata)
    );

    guarded_assign #(.W(1)) u_drv_we (
        .en  (guard[GUARD_CAP]),
        .val (1'b1),
        .dout(reg_we)
    );

endmodule

// File: rtl/fixed_latency_group_checker.sv
// Module: fixed_latency_group_checker
// Port-level checker for fixed_latency_group. It keeps its own run model,
// built only from go and reset, and compares the guarded outputs with it.
module fixed_latency_group_checker #(
    parameter int WIDTH   = 8,
    parameter int LATENCY = 4,
    parameter int MUL_LAT = 3,
    parameter int OP_A    = 6,
    parameter int OP_B    = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               go,
    input logic [WIDTH-1:0]   mul_a,
    input logic [WIDTH-1:0]   mul_b,
    input logic               mul_go,
    input logic [2*WIDTH-1:0] mul_p,
    input logic [2*WIDTH-1:0] reg_wdata,
    input logic               reg_we
);

    int m_rel;
    logic m_act;

    // Independent run model: accept go only when idle, count LATENCY cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_act <= 1'b0;
            m_rel <= 0;
        end else if (!m_act) begin
            m_act <= go;
            m_rel <= 0;
        end else if (m_rel == LATENCY - 1) begin
            m_act <= 1'b0;
            m_rel <= 0;
        end else begin
            m_rel <= m_rel + 1;
        end
    end

    assert_ops_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go == (m_act && m_rel < MUL_LAT));

    assert_operands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |-> (mul_a == WIDTH'(OP_A) && mul_b == WIDTH'(OP_B)));

    assert_capture_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we == (m_act && m_rel == LATENCY - 1));

    assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !m_act |-> (!mul_go && !reg_we && mul_a == '0 && mul_b == '0 && reg_wdata == '0));

    assert_capture_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> reg_wdata == mul_p);

endmodule

bind fixed_latency_group fixed_latency_group_checker #(
    .WIDTH(WIDTH), .LATENCY(LATENCY), .MUL_LAT(MUL_LAT), .OP_A(OP_A), .OP_B(OP_B)
) u_checker (
    .clk(clk), .rst_n(rst_n), .go(go), .mul_a(mul_a), .mul_b(mul_b),
    .mul_go(mul_go), .mul_p(mul_p), .reg_wdata(reg_wdata), .reg_we(reg_we)
);

// File: tb/test_fixed_latency_group.sv
// Bench for fixed_latency_group: a behavioural multiplier and target register
// around the block, plus a per-cycle reference model compared on every clock.
module test_fixed_latency_group;

    localparam int W  = 8;
    localparam int PW = 2 * W;
    localparam int LAT = 4;
    localparam int ML  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [W-1:0]  mul_a, mul_b;
    logic          mul_go, reg_we;
    logic [PW-1:0] mul_p, reg_wdata;
    logic [PW-1:0] pipe [ML];
    logic [PW-1:0] res_q;

    int checks = 0;
    int errors = 0;
    int m_busy = 0;
    int m_rel = 0;
    int go_count = 0;

    always #2 clk = ~clk;

    fixed_latency_group i_fixed_latency_group (
        .clk(clk), .rst_n(rst_n), .go(go),
        .mul_a(mul_a), .mul_b(mul_b), .mul_go(mul_go), .mul_p(mul_p),
        .reg_wdata(reg_wdata), .reg_we(reg_we)
    );

    // Three-stage pipelined multiplier
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ML; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= PW'(mul_a) * PW'(mul_b);
            for (int i = 1; i < ML; i++) pipe[i] <= pipe[i-1];
        end
    end
    assign mul_p = pipe[ML-1];

    // Target register written through the write port
    always @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else if (reg_we) res_q <= reg_wdata;
    end

    // Reference run model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_rel <= 0;
        end else if (m_busy == 0) begin
            m_busy <= go ? 1 : 0; m_rel <= 0;
        end else if (m_rel == LAT - 1) begin
            m_busy <= 0; m_rel <= 0;
        end else begin
            m_rel <= m_rel + 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit eg = (m_busy != 0) && (m_rel < ML);
            automatic bit ew = (m_busy != 0) && (m_rel == LAT - 1);
            chk("R2 R3 mul_go", mul_go, eg);
            chk("R3 mul_a", mul_a, eg ? 6 : 0);
            chk("R3 mul_b", mul_b, eg ? 7 : 0);
            chk("R4 reg_we", reg_we, ew);
            chk("R7 reg_wdata", reg_wdata, ew ? 42 : 0);
            if (m_busy == 0) chk("R6 idle outputs", {mul_go, reg_we}, 0);
            if (mul_go) go_count++;
        end
    end

    task automatic pulse_go();
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: outputs zero under reset
        wait_cyc(3);
        chk("R1 reset mul_go", mul_go, 0);
        chk("R1 reset reg_we", reg_we, 0);
        chk("R1 reset operands", {mul_a, mul_b}, 0);
        chk("R1 reset wdata", reg_wdata, 0);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 after release", {mul_go, reg_we}, 0);

        // R2 R7: a single run leaves 42 in the register
        pulse_go();
        wait_cyc(LAT + 1);
        chk("R7 register result", res_q, 42);

        // R5: pulses in cycles 1 and 3 of a run are ignored
        go_count = 0;
        pulse_go();          // go seen idle; cycle 0 now
        @(negedge clk) go = 1'b1;  // relative cycle 1
        @(negedge clk) go = 1'b0;
        wait_cyc(1);
        go = 1'b1;           // relative cycle 3, last cycle
        @(negedge clk) go = 1'b0;
        wait_cyc(8);
        chk("R5 busy go ignored, mul_go cycles", go_count, ML);
        chk("R7 register after ignored go", res_q, 42);

        // R6: held go restarts in the first idle cycle
        go_count = 0;
        @(negedge clk) go = 1'b1;
        wait_cyc(3 * (LAT + 1));
        go = 1'b0;
        wait_cyc(LAT + 2);
        chk("R6 back-to-back runs, mul_go cycles", go_count, 3 * ML);

        // R1: reset in the middle of a run
        pulse_go();
        wait_cyc(1);
        rst_n = 1'b0;
        wait_cyc(1);
        chk("R1 mid-run reset outputs", {mul_go, reg_we}, 0);
        chk("R1 mid-run reset operands", {mul_a, mul_b}, 0);
        rst_n = 1'b1;
        go_count = 0;
        wait_cyc(LAT + 2);
        chk("R6 idle after reset, mul_go cycles", go_count, 0);

        // R7: a fresh run after reset
        pulse_go();
        wait_cyc(LAT + 1);
        chk("R7 register after reset run", res_q, 42);

        finish_run();
    end

endmodule